// File: doc/BRIEF.md
# Storage Access Permission Checker

This block decides whether a load, a store or an instruction fetch may proceed against a page that has already been found by the translation walk. It takes the protection fields of the page entry (a 3-bit protection code, a no-execute bit, a guarded bit and a class key), the two key bits of the segment entry, the privilege state of the access, and two 64-bit mask registers that strip rights per class key. From these it forms the read, write and execute rights of the page, an allow or deny verdict for the access in hand, and cause-specific fault bits for the exception logic that follows.

Three independent terms each yield a set of rights, and the final rights are their AND:
- a key-dependent protection table;
- a no-execute/guard term;
- a class-key term driven by the access mask and, when enabled, the instruction mask.

The request is sampled on a clock edge and the verdict appears registered one cycle later. Two control inputs select the variant: one turns class-key masking on, and the other adds the instruction-mask check for newer MMU modes.

Top module: `access_perm_check`

## Requirements
- R1: The key used for the protection table is `seg_key_user` when `prob_state` is 1 and `seg_key_sup` when `prob_state` is 0.
- R2: With key 0, protection codes 0, 1 and 2 give read, write and execute; codes 3 and 6 give read and execute; codes 4, 5 and 7 give nothing. The code is `pte_pp`, whose bit 2 is the high protection bit and whose bits 1:0 are the two low protection bits.
- R3: With key 1, code 2 gives read, write and execute; codes 1 and 3 give read and execute; codes 0, 4, 5, 6 and 7 give nothing.
- R4: When `pte_noexec` or `pte_guard` is 1, execute is removed; read and write are not affected by these bits.
- R5: When `class_key_en` is 1, the 2-bit field of `acc_mask` at bit position 2*(31-k), where k is `pte_class_key`, strips rights: its bit 1 removes write and its bit 0 removes read. When `class_key_en` is 0, the class-key term grants all rights.
- R6: When both `class_key_en` and `inst_mask_en` are 1, bit 0 of the field of `inst_mask` at the same position 2*(31-k) removes execute. Otherwise `inst_mask` has no effect.
- R7: `acc_type` 0 is a load and needs read, 1 is a store and needs write, 2 is a fetch and needs execute. `allow` is 1 exactly when the final rights hold the needed right. Code 3 is reserved and is always denied, with every fault bit 0.
- R8: On a denied fetch, `flt_nx_guard` is set when the no-execute/guard term removed execute. Otherwise `flt_prot` is set when the table lacked execute. `flt_class_key` is set when the class-key term removed execute. `flt_store` is 0.
- R9: On a denied load or store, `flt_prot` is set when the table lacks the needed right, `flt_class_key` is set when the class-key term lacks it, `flt_store` is set for a store, and `flt_nx_guard` is 0.
- R10: `resp_valid` and all result outputs appear exactly one cycle after `req_valid`. When `allow` is 1, all fault bits are 0. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| prob_state | input | 1 | Access made in user (problem) state |
| seg_key_user | input | 1 | Segment key bit for user state |
| seg_key_sup | input | 1 | Segment key bit for supervisor state |
| pte_pp | input | 3 | Page protection code |
| pte_noexec | input | 1 | Page no-execute bit |
| pte_guard | input | 1 | Page guarded bit |
| pte_class_key | input | 5 | Page class key |
| acc_mask | input | 64 | Per-key load/store mask register |
| inst_mask | input | 64 | Per-key fetch mask register |
| class_key_en | input | 1 | Enable class-key masking |
| inst_mask_en | input | 1 | Enable fetch-mask check |
| resp_valid | output | 1 | Result present |
| perm_r | output | 1 | Final read right |
| perm_w | output | 1 | Final write right |
| perm_x | output | 1 | Final execute right |
| allow | output | 1 | Access permitted |
| flt_prot | output | 1 | Protection-table fault |
| flt_nx_guard | output | 1 | No-execute/guard fault |
| flt_class_key | output | 1 | Class-key fault |
| flt_store | output | 1 | Faulting access was a store |

## Verification
The protection table and the class-key mask can both refuse the same access in one cycle. The bench provokes this with directed stores on a read-only code whose key field also blocks writes, and with random mask words over all protection codes. Each such case must raise `flt_prot` and `flt_class_key` together. The no-execute/guard term and the table can also both remove execute from the same fetch; there the bench expects only `flt_nx_guard` of the two, so the precedence is checked as well as the overlap.

// File: rtl/apc_pkg.sv
package apc_pkg;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rights_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam rights_t RIGHTS_NONE = 3'b000;
    localparam rights_t RIGHTS_RX   = 3'b101;
    localparam rights_t RIGHTS_ALL  = 3'b111;

endpackage

// File: rtl/apc_prot_table.sv
module apc_prot_table
    import apc_pkg::*;
(
    input  logic       key,
    input  logic [2:0] code,
    output rights_t    rights
);

    always_comb begin
        rights = RIGHTS_NONE;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: rights = RIGHTS_ALL;
                3'd3, 3'd6:       rights = RIGHTS_RX;
                default:          rights = RIGHTS_NONE;
            endcase
        end else begin
            case (code)
                3'd2:       rights = RIGHTS_ALL;
                3'd1, 3'd3: rights = RIGHTS_RX;
                default:    rights = RIGHTS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/apc_key_mask.sv
module apc_key_mask
    import apc_pkg::*;
#(
    parameter int KEY_W = 5,
    localparam int NUM_KEYS = 1 << KEY_W,
    localparam int MASK_W = 2 * NUM_KEYS
) (
    input  logic              key_en,
    input  logic              inst_en,
    input  logic [KEY_W-1:0]  class_key,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic [MASK_W-1:0] inst_mask,
    output rights_t           rights
);

    // field for key k sits at 2*(NUM_KEYS-1-k); NUM_KEYS-1-k equals ~k
    logic [KEY_W-1:0] slot;
    logic [KEY_W:0]   lo_bit;
    logic [1:0]       acc_fld;
    logic             inst_bit;

    assign slot     = ~class_key;
    assign lo_bit   = {slot, 1'b0};
    assign acc_fld  = acc_mask[lo_bit +: 2];
    assign inst_bit = inst_mask[lo_bit];

    always_comb begin
        rights = RIGHTS_ALL;
        if (key_en) begin
            rights.w = ~acc_fld[1];
            rights.r = ~acc_fld[0];
            rights.x = ~(inst_en & inst_bit);
        end
    end

endmodule

// File: rtl/access_perm_check.sv
module access_perm_check
    import apc_pkg::*;
#(
    parameter int KEY_W = 5,
    localparam int MASK_W = 2 * (1 << KEY_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        acc_type,
    input  logic              prob_state,
    input  logic              seg_key_user,
    input  logic              seg_key_sup,
    input  logic [2:0]        pte_pp,
    input  logic              pte_noexec,
    input  logic              pte_guard,
    input  logic [KEY_W-1:0]  pte_class_key,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic [MASK_W-1:0] inst_mask,
    input  logic              class_key_en,
    input  logic              inst_mask_en,
    output logic              resp_valid,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic              allow,
    output logic              flt_prot,
    output logic              flt_nx_guard,
    output logic              flt_class_key,
    output logic              flt_store
);

    logic    eff_key;
    rights_t tbl_rt;
    rights_t nxg_rt;
    rights_t key_rt;
    rights_t fin_rt;
    acc_e    acc;

    logic    tbl_need, key_need, fin_need;
    logic    c_allow, c_prot, c_nxg, c_key, c_store;

    assign eff_key = prob_state ? seg_key_user : seg_key_sup;
    assign acc     = acc_e'(acc_type);

    apc_prot_table u_tbl (
        .key    (eff_key),
        .code   (pte_pp),
        .rights (tbl_rt)
    );

    apc_key_mask #(.KEY_W(KEY_W)) u_key (
        .key_en    (class_key_en),
        .inst_en   (inst_mask_en),
        .class_key (pte_class_key),
        .acc_mask  (acc_mask),
        .inst_mask (inst_mask),
        .rights    (key_rt)
    );

    always_comb begin
        nxg_rt   = RIGHTS_ALL;
        nxg_rt.x = ~(pte_noexec | pte_guard);
    end

    assign fin_rt = tbl_rt & nxg_rt & key_rt;

    always_comb begin
        tbl_need = 1'b0;
        key_need = 1'b0;
        fin_need = 1'b0;
        unique case (acc)
            ACC_LOAD:  begin tbl_need = tbl_rt.r; key_need = key_rt.r; fin_need = fin_rt.r; end
            ACC_STORE: begin tbl_need = tbl_rt.w; key_need = key_rt.w; fin_need = fin_rt.w; end
            ACC_FETCH: begin tbl_need = tbl_rt.x; key_need = key_rt.x; fin_need = fin_rt.x; end
            ACC_RSVD:  begin tbl_need = 1'b0;     key_need = 1'b0;     fin_need = 1'b0;     end
        endcase
    end

    always_comb begin
        c_allow = fin_need;
        c_prot  = 1'b0;
        c_nxg   = 1'b0;
        c_key   = 1'b0;
        c_store = 1'b0;
        if (!fin_need) begin
            unique case (acc)
                ACC_FETCH: begin
                    c_nxg  = ~nxg_rt.x;
                    c_prot = nxg_rt.x & ~tbl_rt.x;
                    c_key  = ~key_rt.x;
                end
                ACC_LOAD, ACC_STORE: begin
                    c_prot  = ~tbl_need;
                    c_key   = ~key_need;
                    c_store = (acc == ACC_STORE);
                end
                ACC_RSVD: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            perm_r        <= 1'b0;
            perm_w        <= 1'b0;
            perm_x        <= 1'b0;
            allow         <= 1'b0;
            flt_prot      <= 1'b0;
            flt_nx_guard  <= 1'b0;
            flt_class_key <= 1'b0;
            flt_store     <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                perm_r        <= fin_rt.r;
                perm_w        <= fin_rt.w;
                perm_x        <= fin_rt.x;
                allow         <= c_allow;
                flt_prot      <= c_prot;
                flt_nx_guard  <= c_nxg;
                flt_class_key <= c_key;
                flt_store     <= c_store;
            end
        end
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R10

    AST_ALLOW_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && allow) |-> !(flt_prot || flt_nx_guard || flt_class_key || flt_store)); // R10

    AST_NXG_KILLS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (pte_noexec || pte_guard)) |=> !perm_x); // R4

    AST_MASK_KILLS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && class_key_en && acc_mask[{~pte_class_key, 1'b1}]) |=> !perm_w); // R5

    AST_RSVD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_type == 2'd3) |=> (!allow && !flt_prot && !flt_class_key && !flt_store && !flt_nx_guard)); // R7

    AST_STORE_FLAG_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && flt_store) |-> !allow); // R9

endmodule

// File: tb/sim_access_perm_check.sv
`timescale 1ns/1ps
module sim_access_perm_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        prob_state = 1'b0;
    logic        seg_key_user = 1'b0;
    logic        seg_key_sup = 1'b0;
    logic [2:0]  pte_pp = '0;
    logic        pte_noexec = 1'b0;
    logic        pte_guard = 1'b0;
    logic [4:0]  pte_class_key = '0;
    logic [63:0] acc_mask = '0;
    logic [63:0] inst_mask = '0;
    logic        class_key_en = 1'b0;
    logic        inst_mask_en = 1'b0;
    logic        resp_valid, perm_r, perm_w, perm_x, allow;
    logic        flt_prot, flt_nx_guard, flt_class_key, flt_store;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    access_perm_check u0 (.*);

    // expected: {allow, r, w, x, prot, nxg, key, store}
    function automatic logic [7:0] ref_model();
        int k, code, t;
        bit tr, tw, tx, mr, mw, mx, nx_ok, need_t, need_m, ok;
        bit fp, fn, fk, fs;
        k = prob_state ? int'(seg_key_user) : int'(seg_key_sup);
        code = int'(pte_pp);
        t = int'(acc_type);
        tr = 0; tw = 0; tx = 0;
        if (k == 0 && code <= 2) begin tr = 1; tw = 1; tx = 1; end
        else if (k == 0 && (code == 3 || code == 6)) begin tr = 1; tx = 1; end
        else if (k == 1 && code == 2) begin tr = 1; tw = 1; tx = 1; end
        else if (k == 1 && (code == 1 || code == 3)) begin tr = 1; tx = 1; end
        nx_ok = !(pte_noexec || pte_guard);
        mr = 1; mw = 1; mx = 1;
        if (class_key_en) begin
            mw = !acc_mask[2*(31-int'(pte_class_key)) + 1];
            mr = !acc_mask[2*(31-int'(pte_class_key))];
            if (inst_mask_en) mx = !inst_mask[2*(31-int'(pte_class_key))];
        end
        need_t = (t == 0) ? tr : (t == 1) ? tw : (t == 2) ? tx : 0;
        need_m = (t == 0) ? mr : (t == 1) ? mw : (t == 2) ? mx : 0;
        ok = (t == 2) ? (tx && nx_ok && mx) : (t == 3) ? 0 : (need_t && need_m);
        fp = 0; fn = 0; fk = 0; fs = 0;
        if (!ok && t == 2) begin
            fn = !nx_ok;
            fp = nx_ok && !tx;
            fk = !mx;
        end else if (!ok && t < 2) begin
            fp = !need_t;
            fk = !need_m;
            fs = (t == 1);
        end
        return {ok, tr & mr, tw & mw, tx & nx_ok & mx, fp, fn, fk, fs};
    endfunction

    function automatic logic [7:0] got();
        return {allow, perm_r, perm_w, perm_x, flt_prot, flt_nx_guard, flt_class_key, flt_store};
    endfunction

    task automatic check_vec(input string tag, input logic [7:0] exp_v);
        n_checks++;
        if (got() !== exp_v || resp_valid !== 1'b1) begin
            n_fails++;
            $display("FAIL %s: got %b valid %b, expected %b valid 1", tag, got(), resp_valid, exp_v);
        end
    endtask

    // drive at negedge, result registered at posedge, compare at next negedge
    task automatic run(input string tag);
        logic [7:0] e;
        req_valid = 1'b1;
        e = ref_model();
        @(negedge clk);
        check_vec(tag, e);
    endtask

    task automatic setup(input int t, input int pr, input int ku, input int ks, input int pp,
                         input int nx, input int gd, input int ck, input int ken, input int ien);
        acc_type = 2'(t); prob_state = 1'(pr); seg_key_user = 1'(ku); seg_key_sup = 1'(ks);
        pte_pp = 3'(pp); pte_noexec = 1'(nx); pte_guard = 1'(gd); pte_class_key = 5'(ck);
        class_key_en = 1'(ken); inst_mask_en = 1'(ien);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        n_checks++;
        if ({resp_valid, got()} !== 9'd0) begin
            n_fails++;
            $display("FAIL R10 reset: got %b, expected 0", {resp_valid, got()});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: key selection by privilege
        setup(0, 1, 1, 0, 0, 0, 0, 0, 0, 0); run("R1 user key1 pp0 load");
        setup(0, 0, 1, 0, 0, 0, 0, 0, 0, 0); run("R1 sup key0 pp0 load");

        // R2 and R3: every code, both keys, each access
        for (int k = 0; k < 2; k++)
            for (int pp = 0; pp < 8; pp++)
                for (int t = 0; t < 3; t++) begin
                    setup(t, 0, 0, k, pp, 0, 0, 0, 0, 0);
                    run(k == 0 ? "R2 table key0" : "R3 table key1");
                end

        // R4: noexec and guard remove only execute
        setup(2, 0, 0, 0, 2, 1, 0, 0, 0, 0); run("R4 noexec fetch");
        setup(1, 0, 0, 0, 2, 0, 1, 0, 0, 0); run("R4 guard store");
        // R8: noexec wins over table when both remove execute
        setup(2, 0, 0, 1, 0, 1, 0, 0, 0, 0); run("R8 nxg over table");
        setup(2, 0, 0, 1, 0, 0, 0, 0, 0, 0); run("R8 table fetch fault");

        // R5: class key 5 write-block field
        acc_mask = 64'd0; acc_mask[2*(31-5)+1] = 1'b1;
        setup(1, 0, 0, 0, 2, 0, 0, 5, 1, 0); run("R5 key write blocked");
        setup(0, 0, 0, 0, 2, 0, 0, 5, 1, 0); run("R5 key read ok");
        setup(1, 0, 0, 0, 2, 0, 0, 5, 0, 0); run("R5 disabled store ok");
        // R9: table and class key both refuse the store
        setup(1, 0, 0, 0, 3, 0, 0, 5, 1, 0); run("R9 prot and key store");
        acc_mask = 64'd0; acc_mask[2*(31-5)] = 1'b1;
        setup(0, 0, 0, 0, 0, 0, 0, 5, 1, 0); run("R9 key load fault");

        // R6: fetch mask on key 9
        inst_mask = 64'd0; inst_mask[2*(31-9)] = 1'b1;
        setup(2, 0, 0, 0, 0, 0, 0, 9, 1, 1); run("R6 fetch mask blocks");
        setup(2, 0, 0, 0, 0, 0, 0, 9, 1, 0); run("R6 fetch mask off");
        setup(2, 0, 0, 0, 0, 0, 0, 9, 0, 1); run("R6 class off");

        // R7: reserved code
        setup(3, 0, 0, 0, 0, 0, 0, 0, 0, 0); run("R7 reserved");

        // R10: idle cycle gives no response
        req_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (resp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 idle: got valid %b, expected 0", resp_valid);
        end

        // R7/R8/R9 random sweep
        for (int i = 0; i < 600; i++) begin
            acc_mask  = {$urandom, $urandom};
            inst_mask = {$urandom, $urandom};
            setup($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 7), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 3) == 0), $urandom_range(0, 31), $urandom_range(0, 1),
                  $urandom_range(0, 1));
            run("R7 random");
        end

        req_valid = 1'b0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule